// File: doc/BRIEF.md
# Byte-Wide Streaming SRAM Controller

This block lets a host with very few spare pins reach a 512K x 8 asynchronous SRAM. The host presents a two-bit command and a data byte, then raises a single strobe. The controller synchronises that strobe into its own clock, finds the rising edge and runs exactly one operation. There are four operations: load the low address byte, load the middle address byte, read a byte and write a byte. Reads and writes may then move the address by one.

The address register is 19 bits wide. Loading the middle byte also clears the top three bits. The host can therefore place the address anywhere in the bottom 64K. Memory above that is reached only by stepping past 0xFFFF with reads or writes. Whether reads and writes step up, step down or leave the address alone is fixed by a build parameter.

The host data bus and the SRAM data bus are each brought out as separate input and output ports with an output-enable. A pad ring or a board-level top combines them into the shared tri-state lines.

Top module: `strm_sram_ctrl`

## Requirements
- R1: After reset the SRAM address is 0, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all high, and neither `host_dout_en` nor `sram_dq_oe` is asserted.
- R2: Command 2'b00 copies `host_din` into address bits 7:0 and leaves bits 18:8 unchanged.
- R3: Command 2'b01 copies `host_din` into address bits 15:8 and sets bits 18:16 to zero. Bits 7:0 are kept.
- R4: Command 2'b10 reads the SRAM byte at the current address. The byte appears on `host_dout` once the access completes, while the strobe is still held high.
- R5: Command 2'b11 writes `host_din` to the current address. `sram_we_n` is low only while `sram_ce_n` is low, the data bus is driven, and the address does not change while `sram_we_n` is low.
- R6: With STEP set to increment, every read and every write adds 1 to the 19-bit address afterwards, carrying across all bits (0x0FFFF becomes 0x10000).
- R7: With STEP set to decrement, every read and every write subtracts 1 afterwards, borrowing across all bits and wrapping modulo 2^19 (0x10000 becomes 0x0FFFF, and 0x00000 becomes 0x7FFFF).
- R8: The two load commands never step the address.
- R9: `host_dout_en` is high only while the command is 2'b10 and the synchronised strobe is high. It is low at all other times.
- R10: Each rising strobe edge runs exactly one operation, however long the strobe stays high.
- R11: `sram_oe_n` and `sram_we_n` are never low together, and `sram_dq_oe` is never asserted while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd | input | 2 | Operation select: 00 load low, 01 load middle, 10 read, 11 write |
| host_strobe | input | 1 | Asynchronous strobe; a rising edge runs one operation |
| host_din | input | 8 | Byte from the host (address byte or write data) |
| host_dout | output | 8 | Byte returned by the last read |
| host_dout_en | output | 1 | Drive enable for the host data bus |
| sram_addr | output | 19 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq_in | input | 8 | Data coming from the SRAM |
| sram_dq_out | output | 8 | Data driven to the SRAM |
| sram_dq_oe | output | 1 | Drive enable for the SRAM data bus |

## Verification
The assertions check the pin discipline of the SRAM on every cycle:
- output enable and write enable are never active together;
- write enable is active only inside chip enable;
- the address holds while write enable is active;
- the data drive is off while the SRAM drives the bus.

They also check, on every cycle, that the strobe detector gives a single-cycle pulse, and the address arithmetic of each load and each step, including the clearing of the top bits.

Only the bench scenarios can show the data path end to end. They compare against a reference memory that covers:
- bytes written and read back;
- walking forwards with one build and backwards with the other;
- crossing the 64K boundary and wrapping below zero into the top of memory;
- a strobe held high for many cycles;
- random loads inside the bottom 64K.

// File: rtl/strm_sram_pkg.sv
package strm_sram_pkg;

   // Post-access address movement, chosen at build time
   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_e;

   // Host command encoding (decoded from host_cmd)
   typedef enum logic [1:0] {
      OP_LOAD_LO = 2'b00,
      OP_LOAD_HI = 2'b01,
      OP_READ    = 2'b10,
      OP_WRITE   = 2'b11
   } op_e;

   // Access sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_WREC  = 2'd3
   } seq_e;

endpackage

// File: rtl/strm_strobe_sync.sv
module strm_strobe_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic level_o,
   output logic rise_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("strm_strobe_sync: SYNC_STAGES must be at least 2");
   end

   // chain[0] is the first flop; chain[SYNC_STAGES] holds the previous level
   logic [SYNC_STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-1:0], strobe_i};
   end

   assign level_o = chain_q[SYNC_STAGES-1];
   assign rise_o  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   // R10: an edge pulse never lasts two cycles
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

   // R10: a pulse is only produced once the level is high
   p_pulse_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> level_o);

endmodule

// File: rtl/strm_addr_reg.sv
module strm_addr_reg
   import strm_sram_pkg::*;
#(
   parameter int    AW   = 19,
   parameter int    DW   = 8,
   parameter step_e STEP = STEP_INC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_lo_i,
   input  logic          ld_hi_i,
   input  logic          step_i,
   input  logic [DW-1:0] din_i,
   output logic [AW-1:0] addr_o
);

   localparam int HI_LSB  = DW;
   localparam int HI_MSB  = 2 * DW - 1;
   localparam int TOP_LSB = 2 * DW;

   if (AW <= 2 * DW) begin : g_bad_width
      $error("strm_addr_reg: AW must exceed two data bytes");
   end

   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_nxt;
   logic [AW-1:0] addr_step;

   // Step arithmetic chosen by build parameter
   if (STEP == STEP_INC) begin : g_inc
      assign addr_step = addr_q + AW'(1);

      // R6: increment carries across the full register
      p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (step_i && !ld_lo_i && !ld_hi_i) |=> (addr_q - $past(addr_q)) == AW'(1));
   end else if (STEP == STEP_DEC) begin : g_dec
      assign addr_step = addr_q - AW'(1);

      // R7: decrement borrows across the full register and wraps
      p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (step_i && !ld_lo_i && !ld_hi_i) |=> ($past(addr_q) - addr_q) == AW'(1));
   end else if (STEP == STEP_NONE) begin : g_hold
      assign addr_step = addr_q;
   end else begin : g_bad_step
      assign addr_step = addr_q;
      $error("strm_addr_reg: unsupported STEP value");
   end

   always_comb begin
      addr_nxt = addr_q;
      if (ld_lo_i) begin
         addr_nxt[DW-1:0] = din_i;
      end else if (ld_hi_i) begin
         addr_nxt[HI_MSB:HI_LSB] = din_i;
         addr_nxt[AW-1:TOP_LSB]  = '0;
      end else if (step_i) begin
         addr_nxt = addr_step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nxt;
   end

   assign addr_o = addr_q;

   // R2: low load keeps every bit above the low byte
   p_low_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo_i |=> (addr_q[AW-1:DW] == $past(addr_q[AW-1:DW]))
                  && (addr_q[DW-1:0] == $past(din_i)));

   // R3: middle load clears the top bits and keeps the low byte
   p_high_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi_i |=> (addr_q[AW-1:TOP_LSB] == '0)
                  && (addr_q[DW-1:0] == $past(addr_q[DW-1:0])));

   // R8: a load never coincides with a step request
   p_load_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_lo_i || ld_hi_i) |-> !step_i);

endmodule

// File: rtl/strm_access_seq.sv
module strm_access_seq
   import strm_sram_pkg::*;
#(
   parameter int DW      = 8,
   parameter int ACC_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  op_e           op_i,
   input  logic [DW-1:0] din_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          ld_lo_o,
   output logic          ld_hi_o,
   output logic          step_o,
   output logic          ce_n_o,
   output logic          oe_n_o,
   output logic          we_n_o,
   output logic          dq_oe_o,
   output logic [DW-1:0] dq_out_o,
   output logic [DW-1:0] rdata_o
);

   localparam int CW = $clog2(ACC_CYC + 1);

   if (ACC_CYC < 1) begin : g_bad_acc
      $error("strm_access_seq: ACC_CYC must be at least 1");
   end

   seq_e          state_q, state_nxt;
   logic [CW-1:0] cnt_q;
   logic          last;
   logic          start;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          ce_n_q, oe_n_q, we_n_q, dq_oe_q;

   assign last  = (cnt_q == CW'(ACC_CYC - 1));
   assign start = go_i && (state_q == SQ_IDLE);

   assign ld_lo_o = start && (op_i == OP_LOAD_LO);
   assign ld_hi_o = start && (op_i == OP_LOAD_HI);
   assign step_o  = ((state_q == SQ_READ) && last) || (state_q == SQ_WREC);

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (start && op_i == OP_READ)       state_nxt = SQ_READ;
            else if (start && op_i == OP_WRITE) state_nxt = SQ_WRITE;
         end
         SQ_READ:  if (last) state_nxt = SQ_IDLE;
         SQ_WRITE: if (last) state_nxt = SQ_WREC;
         SQ_WREC:  state_nxt = SQ_IDLE;
         default:  state_nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
      end else begin
         state_q <= state_nxt;
         cnt_q   <= (state_nxt != state_q) ? '0 : cnt_q + CW'(1);
         if (start && op_i == OP_WRITE)  wdata_q <= din_i;
         if (state_q == SQ_READ && last) rdata_q <= mem_rdata_i;
         // Pin strobes are registered from the next state: glitch free
         ce_n_q  <= (state_nxt == SQ_IDLE);
         oe_n_q  <= (state_nxt != SQ_READ);
         we_n_q  <= (state_nxt != SQ_WRITE);
         dq_oe_q <= (state_nxt == SQ_WRITE) || (state_nxt == SQ_WREC);
      end
   end

   assign ce_n_o   = ce_n_q;
   assign oe_n_o   = oe_n_q;
   assign we_n_o   = we_n_q;
   assign dq_oe_o  = dq_oe_q;
   assign dq_out_o = wdata_q;
   assign rdata_o  = rdata_q;

   // R11: read and write enables are mutually exclusive
   p_oe_we_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n_o && !we_n_o));

   // R5: write enable only inside chip enable, with data driven
   p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |-> (!ce_n_o && dq_oe_o));

   // R11: no bus contention with the SRAM output
   p_no_contend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_o |-> oe_n_o);

   // R5: write data is held during the whole write pulse
   p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n_o && !$rose(dq_oe_o)) |-> $stable(dq_out_o));

endmodule

// File: rtl/strm_sram_ctrl.sv
module strm_sram_ctrl
   import strm_sram_pkg::*;
#(
   parameter int    AW          = 19,
   parameter int    DW          = 8,
   parameter int    ACC_CYC     = 2,
   parameter int    SYNC_STAGES = 2,
   parameter step_e STEP        = STEP_INC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    host_cmd,
   input  logic          host_strobe,
   input  logic [DW-1:0] host_din,
   output logic [DW-1:0] host_dout,
   output logic          host_dout_en,
   output logic [AW-1:0] sram_addr,
   output logic          sram_ce_n,
   output logic          sram_oe_n,
   output logic          sram_we_n,
   input  logic [DW-1:0] sram_dq_in,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe
);

   logic strobe_lvl, strobe_rise;
   logic ld_lo, ld_hi, step;
   op_e  op;

   assign op = op_e'(host_cmd);

   strm_strobe_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (host_strobe),
      .level_o  (strobe_lvl),
      .rise_o   (strobe_rise)
   );

   strm_access_seq #(
      .DW      (DW),
      .ACC_CYC (ACC_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (strobe_rise),
      .op_i        (op),
      .din_i       (host_din),
      .mem_rdata_i (sram_dq_in),
      .ld_lo_o     (ld_lo),
      .ld_hi_o     (ld_hi),
      .step_o      (step),
      .ce_n_o      (sram_ce_n),
      .oe_n_o      (sram_oe_n),
      .we_n_o      (sram_we_n),
      .dq_oe_o     (sram_dq_oe),
      .dq_out_o    (sram_dq_out),
      .rdata_o     (host_dout)
   );

   strm_addr_reg #(
      .AW   (AW),
      .DW   (DW),
      .STEP (STEP)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo_i (ld_lo),
      .ld_hi_i (ld_hi),
      .step_i  (step),
      .din_i   (host_din),
      .addr_o  (sram_addr)
   );

   // Host bus is driven only for a read command with the strobe held
   assign host_dout_en = strobe_lvl && (op == OP_READ);

   // R5: address holds while write enable is low (step lands after release)
   p_addr_hold_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |=> $stable(sram_addr));

   // R4: address holds while the SRAM is driving read data
   p_addr_hold_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

   // R9: host bus never driven without the strobe level
   p_dout_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_dout_en |-> strobe_lvl);

endmodule

// File: tb/strm_sram_ctrl_tb.sv
module strm_sram_model (
   input  logic [18:0] addr,
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        we_n,
   input  logic [7:0]  din,
   output logic [7:0]  dout
);
   logic [7:0] mem [int];

   function automatic logic [7:0] seed_byte(input logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] peek(input logic [18:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return seed_byte(a);
   endfunction

   always @(posedge we_n) if (!ce_n) mem[int'(addr)] = din;

   assign dout = (!ce_n && !oe_n) ? peek(addr) : 8'h00;
endmodule

module strm_sram_ctrl_tb;
   import strm_sram_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd = 2'b00;
   logic        strobe = 1'b0;
   logic [7:0]  din = 8'h00;

   logic [7:0]  dout_up, dout_dn, dqo_up, dqo_dn, dqi_up, dqi_dn;
   logic        en_up, en_dn, ce_up, ce_dn, oe_up, oe_dn, we_up, we_dn, doe_up, doe_dn;
   logic [18:0] addr_up, addr_dn;

   int total = 0;
   int bad = 0;
   int viol = 0;
   bit finished = 1'b0;

   logic [18:0] ea_up, ea_dn;
   logic [7:0]  exp_up [int];
   logic [7:0]  exp_dn [int];

   always #10 clk = ~clk;

   strm_sram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .host_cmd(cmd), .host_strobe(strobe), .host_din(din),
      .host_dout(dout_up), .host_dout_en(en_up), .sram_addr(addr_up),
      .sram_ce_n(ce_up), .sram_oe_n(oe_up), .sram_we_n(we_up),
      .sram_dq_in(dqi_up), .sram_dq_out(dqo_up), .sram_dq_oe(doe_up));

   strm_sram_ctrl #(.STEP(STEP_DEC)) u_dut_dn (
      .clk(clk), .rst_n(rst_n), .host_cmd(cmd), .host_strobe(strobe), .host_din(din),
      .host_dout(dout_dn), .host_dout_en(en_dn), .sram_addr(addr_dn),
      .sram_ce_n(ce_dn), .sram_oe_n(oe_dn), .sram_we_n(we_dn),
      .sram_dq_in(dqi_dn), .sram_dq_out(dqo_dn), .sram_dq_oe(doe_dn));

   strm_sram_model u_mem_up (.addr(addr_up), .ce_n(ce_up), .oe_n(oe_up), .we_n(we_up),
                             .din(dqo_up), .dout(dqi_up));
   strm_sram_model u_mem_dn (.addr(addr_dn), .ce_n(ce_dn), .oe_n(oe_dn), .we_n(we_dn),
                             .din(dqo_dn), .dout(dqi_dn));

   // R11 / R5 pin discipline monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!oe_up && !we_up) viol++;
         if (!oe_dn && !we_dn) viol++;
         if (!we_up && ce_up) viol++;
         if (!we_dn && ce_dn) viol++;
         if (doe_up && !oe_up) viol++;
         if (doe_dn && !oe_dn) viol++;
      end
   end

   function automatic logic [7:0] seed_byte(input logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_rd(input bit dn, input logic [18:0] a);
      if (!dn && exp_up.exists(int'(a))) return exp_up[int'(a)];
      if (dn && exp_dn.exists(int'(a)))  return exp_dn[int'(a)];
      return seed_byte(a);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [7:0] d, input int hold);
      logic [7:0] ru, rdn;
      logic eu, edn;
      string treq_up, treq_dn;
      @(negedge clk);
      cmd = op; din = d; strobe = 1'b1;
      repeat (hold) @(negedge clk);
      ru = dout_up; rdn = dout_dn; eu = en_up; edn = en_dn;
      chk("R9", "dout_en during strobe (up)", {31'b0, eu}, {31'b0, op == 2'b10});
      chk("R9", "dout_en during strobe (dn)", {31'b0, edn}, {31'b0, op == 2'b10});
      case (op)
         2'b00: begin
            ea_up[7:0] = d; ea_dn[7:0] = d;
            treq_up = "R2"; treq_dn = "R2";
         end
         2'b01: begin
            ea_up[15:8] = d; ea_up[18:16] = 3'b0;
            ea_dn[15:8] = d; ea_dn[18:16] = 3'b0;
            treq_up = "R3"; treq_dn = "R3";
         end
         2'b10: begin
            chk("R4", "read byte (up)", {24'b0, ru}, {24'b0, exp_rd(1'b0, ea_up)});
            chk("R4", "read byte (dn)", {24'b0, rdn}, {24'b0, exp_rd(1'b1, ea_dn)});
            ea_up = ea_up + 19'd1; ea_dn = ea_dn - 19'd1;
            treq_up = "R6"; treq_dn = "R7";
         end
         default: begin
            exp_up[int'(ea_up)] = d; exp_dn[int'(ea_dn)] = d;
            ea_up = ea_up + 19'd1; ea_dn = ea_dn - 19'd1;
            treq_up = "R6"; treq_dn = "R7";
         end
      endcase
      strobe = 1'b0;
      repeat (4) @(negedge clk);
      chk(treq_up, "address after op (up)", {13'b0, addr_up}, {13'b0, ea_up});
      chk(treq_dn, "address after op (dn)", {13'b0, addr_dn}, {13'b0, ea_dn});
      chk("R9", "dout_en idle", {30'b0, en_up, en_dn}, 32'd0);
   endtask

   task automatic set_addr(input logic [15:0] a);
      do_op(2'b01, a[15:8], 12);
      do_op(2'b00, a[7:0], 12);
   endtask

   task automatic t_reset();
      chk("R1", "address after reset", {13'b0, addr_up}, 32'd0);
      chk("R1", "controls after reset", {29'b0, ce_up, oe_up, we_up}, 32'd7);
      chk("R1", "bus enables after reset", {30'b0, en_up, doe_up}, 32'd0);
      chk("R1", "dn controls after reset", {29'b0, ce_dn, oe_dn, we_dn}, 32'd7);
   endtask

   task automatic t_loads();
      do_op(2'b00, 8'h34, 12);
      chk("R2", "low load", {13'b0, addr_up}, 32'h00034);
      do_op(2'b01, 8'h12, 12);
      chk("R3", "middle load", {13'b0, addr_up}, 32'h01234);
      do_op(2'b00, 8'hAB, 12);
      chk("R8", "loads do not step", {13'b0, addr_dn}, 32'h012AB);
   endtask

   task automatic t_stream();
      set_addr(16'h0100);
      for (int i = 0; i < 6; i++) do_op(2'b11, 8'hC0 + 8'(i), 12);
      chk("R6", "forward after 6 writes", {13'b0, addr_up}, 32'h00106);
      chk("R7", "backward after 6 writes", {13'b0, addr_dn}, 32'h000FA);
      set_addr(16'h0100);
      for (int i = 0; i < 6; i++) do_op(2'b10, 8'h00, 12);
   endtask

   task automatic t_carry();
      set_addr(16'hFFFE);
      do_op(2'b11, 8'h11, 12);
      do_op(2'b11, 8'h22, 12);
      chk("R6", "carry into bit 16", {13'b0, addr_up}, 32'h10000);
      do_op(2'b10, 8'h00, 12);
      do_op(2'b11, 8'h33, 12);
      do_op(2'b01, 8'h00, 12);
      chk("R3", "middle load clears top bits", {13'b0, addr_up}, 32'h00002);
   endtask

   task automatic t_borrow();
      set_addr(16'h0000);
      do_op(2'b10, 8'h00, 12);
      chk("R7", "wrap below zero", {13'b0, addr_dn}, 32'h7FFFF);
      do_op(2'b10, 8'h00, 12);
      do_op(2'b11, 8'h44, 12);
      set_addr(16'h0001);
      chk("R7", "reload after wrap", {13'b0, addr_dn}, 32'h00001);
   endtask

   task automatic t_hold();
      set_addr(16'h0200);
      do_op(2'b11, 8'h5C, 40);
      chk("R10", "long strobe steps once (up)", {13'b0, addr_up}, 32'h00201);
      chk("R10", "long strobe steps once (dn)", {13'b0, addr_dn}, 32'h001FF);
      set_addr(16'h0200);
      do_op(2'b10, 8'h00, 40);
   endtask

   task automatic t_random();
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 16; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         set_addr(lf);
         do_op(2'b11, lf[7:0] ^ lf[15:8], 12);
      end
      lf = 16'hACE1;
      for (int i = 0; i < 16; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         set_addr(lf);
         do_op(2'b10, 8'h00, 12);
      end
   endtask

   initial begin
      ea_up = '0; ea_dn = '0;
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_loads();
      t_stream();
      t_carry();
      t_borrow();
      t_hold();
      t_random();
      chk("R11", "pin discipline violations", viol, 32'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule